// File: doc/BRIEF.md
# Streaming Hamming ECC generator

This block sits beside a byte-wide data path and computes Hamming-style check codes over fixed-size blocks of the bytes that pass through it. Each code lets a later reader correct any single flipped bit in its block and detect any two flipped bits. Bytes arrive one per clock, qualified by a valid input. An arm strobe starts a new calculation.

A mode bit picks one of two layouts. In the first layout, two codes are built: one over the first 256 bytes after arming and one over the next 256. In the second layout, a single code covers 512 bytes. After the last code of the chosen layout is complete, both code registers hold their values and a done flag stays high until the next arm strobe. Any later bytes are ignored.

Each code is 24 bits wide. It holds six column-parity bits taken over bit positions within a byte and a pair of line-parity bits for each byte-address bit. All parity bits are stored inverted, so a block of erased bytes (all ones) gives an all-ones code.

Top module: `hamming_stream_ecc`

## Requirements
- R1: After `rst_n` is released, both code outputs read all ones and `done` is low. The latched layout is mode 0, so the block counts as armed in mode 0.
- R2: A cycle with `arm` high does four things at that edge: it clears the byte counter and the running parity, sets both codes to all ones, and drops `done`. It also latches `mode_sel` as the layout for the whole run. A byte that is valid in the arm cycle is dropped. Later changes on `mode_sel` have no effect until the next arm.
- R3: Exactly one byte is consumed on each rising edge where `in_valid` is high and `arm` is low. Data on `in_byte` while `in_valid` is low has no effect on any code.
- R4: Code bit layout:
  - Bit 2k (k = 0..2) holds the inverted XOR of the data bits whose bit index has bit k equal to 0. Bit 2k+1 holds the inverted XOR of those whose bit index has bit k equal to 1.
  - Bit 6+2j holds the inverted XOR of all bits of the bytes whose address within the block has bit j equal to 0. Bit 7+2j does the same for address bit j equal to 1.
- R5: In mode 0, bytes 0 to 255 after arming form the block for `code1` and bytes 256 to 511 form the block for `code2`. Each uses an 8-bit in-block address, and bits 23:22 of both codes read 1.
- R6: In mode 1, bytes 0 to 511 form one block for `code1`, using a 9-bit address that fills all 24 bits. `code2` stays all ones for the whole run.
- R7: A code register changes only on the edge that consumes the final byte of its block, and it is visible from the following cycle. Until then it reads all ones.
- R8: `done` rises in the cycle after the final byte of the last block of the latched layout is consumed. It stays high until the next arm strobe.
- R9: While `done` is high, further valid bytes change neither code.
- R10: A block made only of 0xFF bytes gives an all-ones code.
- R11: Flipping one data bit in a block changes exactly one bit of every parity pair (bits 2p and 2p+1) of that block's code. Flipping two bits of one byte leaves at least one pair unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| arm | input | 1 | Strobe that clears the state and starts a new run |
| mode_sel | input | 1 | Layout select latched on arm: 0 = two 256-byte blocks, 1 = one 512-byte block |
| in_valid | input | 1 | Qualifies `in_byte` for this cycle |
| in_byte | input | 8 | Data byte of the stream |
| code1 | output | 24 | Code of the first block (or of the only block in mode 1) |
| code2 | output | 24 | Code of the second block in mode 0 |
| done | output | 1 | Last block of the run is complete; codes are frozen |

## Verification
A wrong byte count or block boundary does not show until a block closes. It then appears as a code written one byte early or late, or written into the wrong register, and `done` rising at the wrong cycle. A corrupted parity accumulator shows as a wrong code in the cycle after the final byte. A failed clear on arm shows as a non-all-ones code or a stale `done` in the cycle straight after the strobe. The bench checks codes directly before and directly after each closing byte, so any off-by-one is visible within one cycle.

// File: rtl/hse_pkg.sv
package hse_pkg;

  localparam int COL_BITS = 6;

  // Column parity of one byte: for each index bit k, the XOR of the data bits
  // with index bit k clear (even slot) and with it set (odd slot).
  function automatic logic [COL_BITS-1:0] col_parity(input logic [7:0] b);
    logic [COL_BITS-1:0] r;
    r = '0;
    for (int k = 0; k < 3; k++) begin
      for (int n = 0; n < 8; n++) begin
        if (((n >> k) & 1) == 1) r[2*k+1] = r[2*k+1] ^ b[n];
        else                     r[2*k]   = r[2*k]   ^ b[n];
      end
    end
    return r;
  endfunction

  function automatic logic byte_parity(input logic [7:0] b);
    return ^b;
  endfunction

endpackage

// File: rtl/hse_sequencer.sv
module hse_sequencer #(
  parameter int AW = 8
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        arm,
  input  logic        mode_sel,
  input  logic        in_valid,
  output logic        take,
  output logic [AW:0] addr,
  output logic        blk_end,
  output logic        sel_code2,
  output logic        mode_q,
  output logic        done
);

  logic [AW:0] cnt_q;
  logic        last_short;
  logic        last_long;
  logic        final_blk;

  assign take       = in_valid & ~arm & ~done;
  assign addr       = cnt_q;
  assign last_short = &cnt_q[AW-1:0];
  assign last_long  = &cnt_q;
  assign blk_end    = take & (mode_q ? last_long : last_short);
  assign final_blk  = blk_end & (mode_q | cnt_q[AW]);
  assign sel_code2  = ~mode_q & cnt_q[AW];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      mode_q <= 1'b0;
      done   <= 1'b0;
    end else if (arm) begin
      cnt_q  <= '0;
      mode_q <= mode_sel;
      done   <= 1'b0;
    end else begin
      if (take)      cnt_q <= cnt_q + 1'b1;
      if (final_blk) done  <= 1'b1;
    end
  end

endmodule

// File: rtl/hse_parity_accum.sv
module hse_parity_accum
  import hse_pkg::*;
#(
  parameter int AW     = 8,
  parameter int CODE_W = 2 * (AW + 1) + COL_BITS
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clear,
  input  logic              take,
  input  logic              blk_end,
  input  logic              mode_q,
  input  logic [AW:0]       addr,
  input  logic [7:0]        din,
  output logic [CODE_W-1:0] code_nxt
);

  localparam int LINE_W = 2 * (AW + 1);

  logic [COL_BITS-1:0] col_q, col_nxt;
  logic [LINE_W-1:0]   line_q, line_nxt;
  logic                bp;
  logic [CODE_W-1:0]   spare_mask;

  assign bp      = byte_parity(din);
  assign col_nxt = col_q ^ col_parity(din);

  for (genvar j = 0; j <= AW; j++) begin : g_line
    assign line_nxt[2*j]   = line_q[2*j]   ^ (bp & ~addr[j]);
    assign line_nxt[2*j+1] = line_q[2*j+1] ^ (bp &  addr[j]);
  end

  // In the short layout the top address pair carries no information.
  assign spare_mask = {2'b11, {(CODE_W-2){1'b0}}};
  assign code_nxt   = ~{line_nxt, col_nxt} | (mode_q ? '0 : spare_mask);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      col_q  <= '0;
      line_q <= '0;
    end else if (clear || blk_end) begin
      col_q  <= '0;
      line_q <= '0;
    end else if (take) begin
      col_q  <= col_nxt;
      line_q <= line_nxt;
    end
  end

endmodule

// File: rtl/hse_code_bank.sv
module hse_code_bank #(
  parameter int CODE_W = 24
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clear,
  input  logic              wr1,
  input  logic              wr2,
  input  logic [CODE_W-1:0] din,
  output logic [CODE_W-1:0] code1,
  output logic [CODE_W-1:0] code2
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      code1 <= '1;
      code2 <= '1;
    end else if (clear) begin
      code1 <= '1;
      code2 <= '1;
    end else begin
      if (wr1) code1 <= din;
      if (wr2) code2 <= din;
    end
  end

endmodule

// File: rtl/hamming_stream_ecc.sv
module hamming_stream_ecc #(
  parameter int BLK_AW = 8,
  parameter int CODE_W = 2 * (BLK_AW + 1) + 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              arm,
  input  logic              mode_sel,
  input  logic              in_valid,
  input  logic [7:0]        in_byte,
  output logic [CODE_W-1:0] code1,
  output logic [CODE_W-1:0] code2,
  output logic              done
);

  logic              take;
  logic [BLK_AW:0]   addr;
  logic              blk_end;
  logic              sel_code2;
  logic              mode_q;
  logic [CODE_W-1:0] code_nxt;
  logic              wr1, wr2;

  hse_sequencer #(.AW(BLK_AW)) u_seq (
    .clk      (clk),
    .rst_n    (rst_n),
    .arm      (arm),
    .mode_sel (mode_sel),
    .in_valid (in_valid),
    .take     (take),
    .addr     (addr),
    .blk_end  (blk_end),
    .sel_code2(sel_code2),
    .mode_q   (mode_q),
    .done     (done)
  );

  hse_parity_accum #(.AW(BLK_AW), .CODE_W(CODE_W)) u_acc (
    .clk     (clk),
    .rst_n   (rst_n),
    .clear   (arm),
    .take    (take),
    .blk_end (blk_end),
    .mode_q  (mode_q),
    .addr    (addr),
    .din     (in_byte),
    .code_nxt(code_nxt)
  );

  assign wr1 = blk_end & ~sel_code2;
  assign wr2 = blk_end &  sel_code2;

  hse_code_bank #(.CODE_W(CODE_W)) u_bank (
    .clk  (clk),
    .rst_n(rst_n),
    .clear(arm),
    .wr1  (wr1),
    .wr2  (wr2),
    .din  (code_nxt),
    .code1(code1),
    .code2(code2)
  );

endmodule

// File: rtl/hse_checker.sv
module hse_checker #(
  parameter int CODE_W = 24
) (
  input logic              clk,
  input logic              rst_n,
  input logic              arm,
  input logic              mode_q,
  input logic              blk_end,
  input logic              done,
  input logic [CODE_W-1:0] code1,
  input logic [CODE_W-1:0] code2
);

  assert_arm_clears_R2: assert property (@(posedge clk) disable iff (!rst_n)
    arm |=> (!done && code1 == '1 && code2 == '1));

  assert_done_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !arm) |=> done);

  assert_done_cause_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(done) |-> $past(blk_end));

  assert_frozen_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !arm) |=> ($stable(code1) && $stable(code2)));

  assert_hold_between_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (!blk_end && !arm) |=> ($stable(code1) && $stable(code2)));

  assert_code2_idle_R6: assert property (@(posedge clk) disable iff (!rst_n)
    mode_q |-> (code2 == '1));

  assert_spare_ones_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !mode_q |-> (code1[CODE_W-1 -: 2] == 2'b11 && code2[CODE_W-1 -: 2] == 2'b11));

endmodule

bind hamming_stream_ecc hse_checker #(.CODE_W(CODE_W)) u_chk (
  .clk    (clk),
  .rst_n  (rst_n),
  .arm    (arm),
  .mode_q (mode_q),
  .blk_end(blk_end),
  .done   (done),
  .code1  (code1),
  .code2  (code2)
);

// File: tb/hamming_stream_ecc_bench.sv
`timescale 1ns/1ps
module hamming_stream_ecc_bench;

  localparam int CW = 24;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          arm = 1'b0;
  logic          mode_sel = 1'b0;
  logic          in_valid = 1'b0;
  logic [7:0]    in_byte = '0;
  logic [CW-1:0] code1, code2;
  logic          done;

  int  vec = 0;
  int  bad = 0;
  bit  ended = 1'b0;
  logic [7:0] mem [512];

  always #2.5 clk = ~clk;

  hamming_stream_ecc u_hamming_stream_ecc (
    .clk(clk), .rst_n(rst_n), .arm(arm), .mode_sel(mode_sel),
    .in_valid(in_valid), .in_byte(in_byte),
    .code1(code1), .code2(code2), .done(done)
  );

  task automatic check(input bit ok, input string req, input string what,
                       input logic [CW-1:0] act, input logic [CW-1:0] exp);
    vec++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s act=%h exp=%h", req, what, act, exp);
    end
  endtask

  // Reference code computed by counting ones, independent of any incremental form.
  function automatic logic [CW-1:0] ref_code(input int base, input int len, input int abits);
    logic [CW-1:0] r;
    r = '1;
    for (int k = 0; k < 3; k++) begin
      for (int s = 0; s < 2; s++) begin
        int ones = 0;
        for (int i = 0; i < len; i++)
          for (int n = 0; n < 8; n++)
            if (((n >> k) & 1) == s && mem[base+i][n]) ones++;
        r[2*k+s] = ~ones[0];
      end
    end
    for (int j = 0; j < abits; j++) begin
      for (int s = 0; s < 2; s++) begin
        int ones = 0;
        for (int i = 0; i < len; i++)
          if (((i >> j) & 1) == s) ones += $countones(mem[base+i]);
        r[6+2*j+s] = ~ones[0];
      end
    end
    return r;
  endfunction

  function automatic bit pairs_split(input logic [CW-1:0] d, input int npairs);
    bit ok = 1'b1;
    for (int p = 0; p < npairs; p++)
      if ((d[2*p] ^ d[2*p+1]) != 1'b1) ok = 1'b0;
    return ok;
  endfunction

  task automatic drive(input logic v, input logic [7:0] b);
    @(negedge clk);
    in_valid = v;
    in_byte  = b;
  endtask

  task automatic idle();
    @(negedge clk);
    in_valid = 1'b0;
    in_byte  = 8'h00;
  endtask

  task automatic do_arm(input logic m);
    @(negedge clk);
    arm = 1'b1; mode_sel = m; in_valid = 1'b1; in_byte = 8'hA5;
    @(negedge clk);
    arm = 1'b0; in_valid = 1'b0; mode_sel = ~m;
  endtask

  task automatic feed(input int base, input int n, input bit gaps);
    for (int i = 0; i < n; i++) begin
      if (gaps && (i % 7) == 3) drive(1'b0, 8'h5A ^ 8'(i));
      drive(1'b1, mem[base+i]);
    end
  endtask

  task automatic fill_pattern();
    for (int i = 0; i < 512; i++) mem[i] = 8'((i * 37 + 11) ^ (i >> 4));
  endtask

  logic [CW-1:0] c1a, c2a, l1, d;

  initial begin
    fill_pattern();
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check(code1 == '1 && code2 == '1, "R1", "codes after reset", code1, '1);
    check(done == 1'b0, "R1", "done after reset", {23'b0, done}, '0);

    // Mode 0, two blocks, with idle gaps carrying junk data
    do_arm(1'b0);
    feed(0, 255, 1'b1);
    idle();
    check(code1 == '1 && done == 1'b0, "R3", "code1 before closing byte (R7)", code1, '1);
    feed(255, 1, 1'b0);
    idle();
    check(code1 == ref_code(0, 256, 8), "R4", "mode0 code1 (R5)", code1, ref_code(0, 256, 8));
    check(code2 == '1 && done == 1'b0, "R7", "code2 before its block ends", code2, '1);
    feed(256, 255, 1'b1);
    idle();
    check(code2 == '1 && done == 1'b0, "R7", "code2 one byte early", code2, '1);
    feed(511, 1, 1'b0);
    idle();
    check(code2 == ref_code(256, 256, 8), "R5", "mode0 code2", code2, ref_code(256, 256, 8));
    check(done == 1'b1, "R8", "done after second block", {23'b0, done}, 24'd1);
    check(code1[23:22] == 2'b11, "R5", "spare bits of code1", code1, ref_code(0, 256, 8));
    c1a = code1; c2a = code2;
    feed(100, 30, 1'b0);
    idle();
    check(code1 == c1a && code2 == c2a, "R9", "codes frozen after done", code1 ^ code2, c1a ^ c2a);
    check(done == 1'b1, "R8", "done stays high", {23'b0, done}, 24'd1);

    // Mode 1, arm with a valid byte in the same cycle
    do_arm(1'b1);
    check(code1 == '1 && code2 == '1 && done == 1'b0, "R2", "state after arm", code1, '1);
    feed(0, 511, 1'b1);
    idle();
    check(code1 == '1 && done == 1'b0, "R7", "mode1 code1 one byte early", code1, '1);
    feed(511, 1, 1'b0);
    idle();
    check(code1 == ref_code(0, 512, 9), "R6", "mode1 code1 (R2 latched mode)", code1, ref_code(0, 512, 9));
    check(code2 == '1, "R6", "mode1 code2 unused", code2, '1);
    check(done == 1'b1, "R8", "mode1 done", {23'b0, done}, 24'd1);
    l1 = code1;

    // Single-bit flip in the long layout
    mem[300][2] = ~mem[300][2];
    do_arm(1'b1);
    feed(0, 512, 1'b0);
    idle();
    d = code1 ^ l1;
    check(pairs_split(d, 12), "R11", "mode1 single flip pairs", d, 24'hxxxxxx);
    fill_pattern();

    // Single-bit flip in the short layout, first block only
    mem[100][5] = ~mem[100][5];
    do_arm(1'b0);
    feed(0, 512, 1'b0);
    idle();
    d = code1 ^ c1a;
    check(pairs_split(d, 11) && d[23:22] == 2'b00, "R11", "mode0 single flip pairs", d, 24'hxxxxxx);
    check(code2 == c2a, "R5", "second block unaffected", code2, c2a);

    // Double-bit flip in one byte
    mem[100][6] = ~mem[100][6];
    do_arm(1'b0);
    feed(0, 256, 1'b0);
    idle();
    d = code1 ^ c1a;
    check(d != '0 && !pairs_split(d, 11), "R11", "double flip detected", d, 24'hxxxxxx);
    fill_pattern();

    // Erased blocks
    for (int i = 0; i < 512; i++) mem[i] = 8'hFF;
    do_arm(1'b1);
    feed(0, 512, 1'b1);
    idle();
    check(code1 == '1 && done == 1'b1, "R10", "erased 512-byte block", code1, '1);
    do_arm(1'b0);
    feed(0, 512, 1'b0);
    idle();
    check(code1 == '1 && code2 == '1 && done == 1'b1, "R10", "erased 256-byte blocks", code1 & code2, '1);

    ended = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vec, bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!ended) begin
      vec++;
      bad++;
      $display("FAIL watchdog run did not finish act=%0d exp=%0d", 0, 1);
      $display("== %0d vectors applied, %0d miscompares ==", vec, bad);
      $finish;
    end
  end

endmodule